// File: doc/BRIEF.md
# Direct Segment Address Translator

This block is a per-core translator that maps one contiguous range of virtual pages onto one contiguous range of physical pages. Three privileged page-number registers describe the range: a lower bound, an exclusive upper bound, and a signed displacement. The displacement is the physical start page of the backing memory minus the lower bound. Every data virtual address is presented to the block at the same time as it is presented to the data TLB. Both lookups run concurrently, and each address is translated by exactly one of them.

Inside the range, the physical page is the virtual page plus the displacement. The TLB outcome for that access is discarded, and no page-walk request is raised, so the range can never take a TLB miss. Outside the range, the TLB result (hit flag, physical address, permissions) passes through unchanged. A page walk is requested only when neither path hits. All three registers hold 4 KB page numbers. The 12-bit page offset is neither stored nor translated. Results are registered and appear one cycle after the request.

Top module: `dseg_xlate`

## Requirements
- R1: After reset, rsp_valid, walk_req and priv_fault are 0 and all three registers are 0, so the segment is empty and every request goes to the TLB path.
- R2: A request whose virtual page (req_va[47:12]) satisfies lower ≤ page < upper is a segment hit: rsp_seg_hit is 1. The lower bound is inclusive and the upper bound is exclusive.
- R3: On a segment hit, rsp_pa[40:12] equals the low 29 bits of (virtual page + displacement), taken modulo 2^36.
- R4: On a segment hit, the TLB inputs are ignored: rsp_hit=1, walk_req=0 and rsp_perm=2'b11 (bit 0 read, bit 1 write), whatever tlb_hit, tlb_pa and tlb_perm carry.
- R5: On a segment miss, rsp_hit equals tlb_hit, and rsp_pa and rsp_perm equal tlb_pa and tlb_perm from the request cycle.
- R6: walk_req is 1 exactly when a valid request hits neither the segment nor the TLB.
- R7: When the upper bound is not above the lower bound (including equal), no address is a segment hit.
- R8: rsp_valid follows req_valid with a latency of one cycle. Every response field belongs to the request of the previous cycle.
- R9: A privileged write (cfg_we=1, cfg_priv=1) with cfg_sel 0 loads the lower bound, 1 the upper bound, and 2 the displacement; cfg_sel 3 changes nothing. A request in the same cycle as a write uses the old values, and requests from the next cycle on use the new ones.
- R10: A write with cfg_priv=0 changes no register and raises priv_fault for exactly the following cycle.
- R11: On a segment hit, rsp_pa[11:0] equals req_va[11:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_priv | input | 1 | Write issued in privileged mode |
| cfg_sel | input | 2 | Register select: 0 lower, 1 upper, 2 displacement |
| cfg_wdata | input | 36 | Page number to write |
| req_valid | input | 1 | Translation request valid |
| req_va | input | 48 | Data virtual address |
| tlb_hit | input | 1 | TLB hit for this request |
| tlb_pa | input | 41 | TLB physical address |
| tlb_perm | input | 2 | TLB permissions {write, read} |
| rsp_valid | output | 1 | Response valid |
| rsp_hit | output | 1 | Translation available from either path |
| rsp_seg_hit | output | 1 | Translated by the segment |
| rsp_pa | output | 41 | Physical address |
| rsp_perm | output | 2 | Permissions {write, read} |
| walk_req | output | 1 | Page walk request |
| priv_fault | output | 1 | Privilege fault pulse |

## Verification
The assertions assume three things about the inputs. The TLB inputs arrive in the same cycle as req_valid. The inputs are stable at the sampling edge. The checks that look one cycle back start only after a full cycle out of reset, because they assume req_valid and cfg_we are idle while reset is held. The stimulus meets these assumptions by driving every input on the falling edge and by keeping all strobes low during reset. The random phase places addresses close to the programmed bounds and deliberately issues writes in the same cycle as requests, so the old-value/new-value ordering is exercised as well as the range edges.

// File: rtl/dseg_pkg.sv
package dseg_pkg;

  localparam int DEF_VA_W      = 48;
  localparam int DEF_PA_W      = 41;
  localparam int DEF_PAGE_BITS = 12;

  typedef enum logic [1:0] {
    SEL_LOWER = 2'd0,
    SEL_UPPER = 2'd1,
    SEL_DISP  = 2'd2,
    SEL_NONE  = 2'd3
  } seg_sel_e;

  localparam logic [1:0] PERM_RW = 2'b11;

endpackage

// File: rtl/dseg_regs.sv
module dseg_regs
  import dseg_pkg::*;
#(
  parameter int VPN_W = 36
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic             priv,
  input  seg_sel_e         sel,
  input  logic [VPN_W-1:0] wdata,
  output logic [VPN_W-1:0] lower,
  output logic [VPN_W-1:0] upper,
  output logic [VPN_W-1:0] disp,
  output logic             seg_en,
  output logic             fault
);

  localparam int NREG = 3;

  logic [VPN_W-1:0] regs_q [NREG];
  logic             wr_ok;
  logic             wr_bad;

  assign wr_ok  = we && priv;
  assign wr_bad = we && !priv;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_q[g] <= '0;
      end else if (wr_ok && (sel == seg_sel_e'(g))) begin
        regs_q[g] <= wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault <= 1'b0;
    end else begin
      fault <= wr_bad;
    end
  end

  assign lower  = regs_q[SEL_LOWER];
  assign upper  = regs_q[SEL_UPPER];
  assign disp   = regs_q[SEL_DISP];
  assign seg_en = upper > lower;

endmodule

// File: rtl/dseg_match.sv
module dseg_match #(
  parameter int VA_W      = 48,
  parameter int PA_W      = 41,
  parameter int PAGE_BITS = 12
) (
  input  logic [VA_W-1:0]           va,
  input  logic [VA_W-PAGE_BITS-1:0] lower,
  input  logic [VA_W-PAGE_BITS-1:0] upper,
  input  logic [VA_W-PAGE_BITS-1:0] disp,
  output logic                      in_range,
  output logic [PA_W-1:0]           seg_pa
);

  localparam int VPN_W = VA_W - PAGE_BITS;
  localparam int PPN_W = PA_W - PAGE_BITS;

  function automatic logic range_hit(input logic [VPN_W-1:0] vpn,
                                     input logic [VPN_W-1:0] lo,
                                     input logic [VPN_W-1:0] hi);
    return (vpn >= lo) && (vpn < hi);
  endfunction

  function automatic logic [PA_W-1:0] shift_addr(input logic [VA_W-1:0]  v,
                                                 input logic [VPN_W-1:0] d);
    logic [VPN_W-1:0] sum;
    sum = v[VA_W-1:PAGE_BITS] + d;
    return {sum[PPN_W-1:0], v[PAGE_BITS-1:0]};
  endfunction

  assign in_range = range_hit(va[VA_W-1:PAGE_BITS], lower, upper);
  assign seg_pa   = shift_addr(va, disp);

endmodule

// File: rtl/dseg_steer.sv
module dseg_steer
  import dseg_pkg::*;
#(
  parameter int PA_W = 41
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            in_range,
  input  logic [PA_W-1:0] seg_pa,
  input  logic            tlb_hit,
  input  logic [PA_W-1:0] tlb_pa,
  input  logic [1:0]      tlb_perm,
  output logic            rsp_valid,
  output logic            rsp_hit,
  output logic            rsp_seg_hit,
  output logic [PA_W-1:0] rsp_pa,
  output logic [1:0]      rsp_perm,
  output logic            walk_req
);

  logic            take_seg;
  logic            any_hit;
  logic            need_walk;
  logic [PA_W-1:0] pa_sel;
  logic [1:0]      perm_sel;

  always_comb begin
    take_seg  = req_valid && in_range;
    any_hit   = req_valid && (in_range || tlb_hit);
    need_walk = req_valid && !in_range && !tlb_hit;
    pa_sel    = in_range ? seg_pa  : tlb_pa;
    perm_sel  = in_range ? PERM_RW : tlb_perm;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_hit     <= 1'b0;
      rsp_seg_hit <= 1'b0;
      rsp_pa      <= '0;
      rsp_perm    <= '0;
      walk_req    <= 1'b0;
    end else begin
      rsp_valid   <= req_valid;
      rsp_hit     <= any_hit;
      rsp_seg_hit <= take_seg;
      rsp_pa      <= pa_sel;
      rsp_perm    <= perm_sel;
      walk_req    <= need_walk;
    end
  end

endmodule

// File: rtl/dseg_xlate.sv
module dseg_xlate
  import dseg_pkg::*;
#(
  parameter int VA_W      = DEF_VA_W,
  parameter int PA_W      = DEF_PA_W,
  parameter int PAGE_BITS = DEF_PAGE_BITS
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic                      cfg_priv,
  input  logic [1:0]                cfg_sel,
  input  logic [VA_W-PAGE_BITS-1:0] cfg_wdata,
  input  logic                      req_valid,
  input  logic [VA_W-1:0]           req_va,
  input  logic                      tlb_hit,
  input  logic [PA_W-1:0]           tlb_pa,
  input  logic [1:0]                tlb_perm,
  output logic                      rsp_valid,
  output logic                      rsp_hit,
  output logic                      rsp_seg_hit,
  output logic [PA_W-1:0]           rsp_pa,
  output logic [1:0]                rsp_perm,
  output logic                      walk_req,
  output logic                      priv_fault
);

  localparam int VPN_W = VA_W - PAGE_BITS;

  logic [VPN_W-1:0] lower;
  logic [VPN_W-1:0] upper;
  logic [VPN_W-1:0] disp;
  logic             seg_en;
  logic             in_range;
  logic [PA_W-1:0]  seg_pa;

  dseg_regs #(.VPN_W(VPN_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (cfg_we),
    .priv   (cfg_priv),
    .sel    (seg_sel_e'(cfg_sel)),
    .wdata  (cfg_wdata),
    .lower  (lower),
    .upper  (upper),
    .disp   (disp),
    .seg_en (seg_en),
    .fault  (priv_fault)
  );

  dseg_match #(.VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS)) u_match (
    .va       (req_va),
    .lower    (lower),
    .upper    (upper),
    .disp     (disp),
    .in_range (in_range),
    .seg_pa   (seg_pa)
  );

  dseg_steer #(.PA_W(PA_W)) u_steer (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .in_range    (in_range),
    .seg_pa      (seg_pa),
    .tlb_hit     (tlb_hit),
    .tlb_pa      (tlb_pa),
    .tlb_perm    (tlb_perm),
    .rsp_valid   (rsp_valid),
    .rsp_hit     (rsp_hit),
    .rsp_seg_hit (rsp_seg_hit),
    .rsp_pa      (rsp_pa),
    .rsp_perm    (rsp_perm),
    .walk_req    (walk_req)
  );

endmodule

// File: rtl/dseg_xlate_chk.sv
module dseg_xlate_chk #(
  parameter int PAGE_BITS = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic [PAGE_BITS-1:0] req_lo,
  input logic                 tlb_hit,
  input logic                 cfg_we,
  input logic                 cfg_priv,
  input logic                 rsp_valid,
  input logic                 rsp_hit,
  input logic                 rsp_seg_hit,
  input logic [PAGE_BITS-1:0] rsp_lo,
  input logic [1:0]           rsp_perm,
  input logic                 walk_req,
  input logic                 priv_fault,
  input logic                 seg_en,
  input logic                 in_range
);

  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assert_walk_only_on_miss_R6: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req |-> (rsp_valid && !rsp_hit && !rsp_seg_hit));

  assert_seg_overrides_tlb_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_seg_hit |-> (rsp_hit && !walk_req && rsp_perm == 2'b11));

  assert_empty_segment_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_range |-> seg_en);

  assert_one_cycle_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (rsp_valid == $past(req_valid)));

  assert_fault_after_user_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && priv_fault) |-> $past(cfg_we && !cfg_priv));

  assert_page_offset_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && rsp_seg_hit) |-> (rsp_lo == $past(req_lo)));

  assert_miss_follows_tlb_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && rsp_valid && !rsp_seg_hit) |-> (rsp_hit == $past(tlb_hit)));

endmodule

bind dseg_xlate dseg_xlate_chk #(.PAGE_BITS(PAGE_BITS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_lo      (req_va[PAGE_BITS-1:0]),
  .tlb_hit     (tlb_hit),
  .cfg_we      (cfg_we),
  .cfg_priv    (cfg_priv),
  .rsp_valid   (rsp_valid),
  .rsp_hit     (rsp_hit),
  .rsp_seg_hit (rsp_seg_hit),
  .rsp_lo      (rsp_pa[PAGE_BITS-1:0]),
  .rsp_perm    (rsp_perm),
  .walk_req    (walk_req),
  .priv_fault  (priv_fault),
  .seg_en      (seg_en),
  .in_range    (in_range)
);

// File: tb/test_dseg_xlate.sv
module test_dseg_xlate;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_priv = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [35:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [47:0] req_va = '0;
  logic        tlb_hit = 1'b0;
  logic [40:0] tlb_pa = '0;
  logic [1:0]  tlb_perm = 2'b00;
  logic        rsp_valid, rsp_hit, rsp_seg_hit, walk_req, priv_fault;
  logic [40:0] rsp_pa;
  logic [1:0]  rsp_perm;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  dseg_xlate i_dseg_xlate (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_priv(cfg_priv),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
    .req_va(req_va), .tlb_hit(tlb_hit), .tlb_pa(tlb_pa), .tlb_perm(tlb_perm),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_seg_hit(rsp_seg_hit),
    .rsp_pa(rsp_pa), .rsp_perm(rsp_perm), .walk_req(walk_req),
    .priv_fault(priv_fault)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference model: page-number registers kept as plain integers.
  longint m_lo = 0, m_hi = 0, m_disp = 0;
  bit     have_exp = 0;
  bit     e_valid, e_hit, e_seg, e_walk, e_fault;
  longint e_pa;
  int     e_perm;

  function automatic longint model_pa(longint va, longint disp);
    longint page;
    page = ((va >> 12) + disp) % (64'd1 << 36);
    return ((page % (64'd1 << 29)) << 12) + (va % 4096);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lo = 0; m_hi = 0; m_disp = 0; have_exp = 0;
    end else begin
      longint vpn;
      bit seg;
      vpn      = longint'(req_va) >> 12;
      seg      = (vpn >= m_lo) && (vpn < m_hi);
      e_valid  = req_valid;
      e_seg    = req_valid && seg;
      e_hit    = req_valid && (seg || tlb_hit);
      e_walk   = req_valid && !seg && !tlb_hit;
      e_fault  = cfg_we && !cfg_priv;
      e_pa     = seg ? model_pa(longint'(req_va), m_disp) : longint'(tlb_pa);
      e_perm   = seg ? 3 : int'(tlb_perm);
      have_exp = 1;
      if (cfg_we && cfg_priv) begin
        case (cfg_sel)
          2'd0: m_lo   = longint'(cfg_wdata);
          2'd1: m_hi   = longint'(cfg_wdata);
          2'd2: m_disp = longint'(cfg_wdata);
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && have_exp) begin
      check(rsp_valid == e_valid, "R8 rsp_valid", rsp_valid, e_valid);
      check(walk_req == e_walk, "R6 walk_req", walk_req, e_walk);
      check(priv_fault == e_fault, "R10 priv_fault", priv_fault, e_fault);
      check(rsp_seg_hit == e_seg, "R2 seg_hit", rsp_seg_hit, e_seg);
      check(rsp_hit == e_hit, "R4/R5 rsp_hit", rsp_hit, e_hit);
      if (e_valid) begin
        check(longint'(rsp_pa) == e_pa, e_seg ? "R3 seg pa" : "R5 tlb pa", rsp_pa, e_pa);
        check(int'(rsp_perm) == e_perm, e_seg ? "R4 perm" : "R5 perm", rsp_perm, e_perm);
      end
    end
  end

  task automatic step(input bit we, input bit pv, input logic [1:0] sel, input logic [35:0] wd,
                      input bit rv, input logic [47:0] va, input bit th,
                      input logic [40:0] tpa, input logic [1:0] tpm);
    cfg_we = we; cfg_priv = pv; cfg_sel = sel; cfg_wdata = wd;
    req_valid = rv; req_va = va; tlb_hit = th; tlb_pa = tpa; tlb_perm = tpm;
    @(negedge clk);
    cfg_we = 0; req_valid = 0;
  endtask

  task automatic wr(input bit pv, input logic [1:0] sel, input logic [35:0] wd);
    step(1, pv, sel, wd, 0, '0, 0, '0, 2'b00);
  endtask

  task automatic rq(input logic [47:0] va, input bit th, input logic [40:0] tpa, input logic [1:0] tpm);
    step(0, 0, 2'd0, '0, 1, va, th, tpa, tpm);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  localparam logic [35:0] LO   = 36'h000123400;
  localparam logic [35:0] HI   = 36'h000123500;
  localparam logic [35:0] PST  = 36'h000100000;
  localparam logic [35:0] DISP = PST - LO;

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(rsp_valid == 0 && walk_req == 0 && priv_fault == 0, "R1 reset outputs",
          {rsp_valid, walk_req, priv_fault}, 0);
    rst_n = 1;
    @(negedge clk);
    // R1: empty segment after reset, address 0 page goes to TLB
    rq(48'h0, 0, '0, 2'b00);
    check(rsp_seg_hit == 0 && walk_req == 1, "R1 empty after reset", {rsp_seg_hit, walk_req}, 1);

    wr(1, 2'd0, LO);
    wr(1, 2'd1, HI);
    wr(1, 2'd2, DISP);
    // R2/R3/R4: lower bound inclusive, TLB miss suppressed
    rq({LO, 12'h000}, 0, 41'h1FFFF, 2'b01);
    check(rsp_seg_hit == 1, "R2 lower bound inclusive", rsp_seg_hit, 1);
    check(rsp_pa == {PST[28:0], 12'h000}, "R3 translated address", rsp_pa, {PST[28:0], 12'h000});
    check(walk_req == 0 && rsp_hit == 1 && rsp_perm == 2'b11, "R4 tlb suppressed",
          {walk_req, rsp_hit, rsp_perm}, 4'b0111);
    // R2/R5: upper bound exclusive, TLB passes through
    rq({HI, 12'h010}, 1, 41'h0ABCDE123, 2'b01);
    check(rsp_seg_hit == 0 && rsp_pa == 41'h0ABCDE123 && rsp_perm == 2'b01, "R5 pass-through",
          rsp_pa, 41'h0ABCDE123);
    // R11: page offset kept on the last page of the range
    rq({HI - 36'd1, 12'hABC}, 1, 41'h5, 2'b00);
    check(rsp_pa[11:0] == 12'hABC, "R11 page offset", rsp_pa[11:0], 12'hABC);
    check(rsp_pa[40:12] == 29'h1000FF, "R3 last page", rsp_pa[40:12], 29'h1000FF);
    // R6: below range and TLB miss requests a walk
    rq({LO - 36'd1, 12'h000}, 0, '0, 2'b00);
    check(walk_req == 1 && rsp_hit == 0, "R6 walk on double miss", walk_req, 1);
    // R10: user write ignored and faults
    wr(0, 2'd0, 36'h0);
    check(priv_fault == 1, "R10 fault pulse", priv_fault, 1);
    rq({LO, 12'h000}, 0, '0, 2'b00);
    check(rsp_seg_hit == 1 && priv_fault == 0, "R10 write ignored", rsp_seg_hit, 1);
    // R9: select 3 changes nothing
    wr(1, 2'd3, 36'h0);
    rq({LO, 12'h000}, 0, '0, 2'b00);
    check(rsp_seg_hit == 1, "R9 select 3 ignored", rsp_seg_hit, 1);
    // R9/R7: write with request in the same cycle uses old values, then disables
    step(1, 1, 2'd1, LO, 1, {LO, 12'h000}, 0, '0, 2'b00);
    check(rsp_seg_hit == 1, "R9 old values same cycle", rsp_seg_hit, 1);
    rq({LO, 12'h000}, 0, '0, 2'b00);
    check(rsp_seg_hit == 0 && walk_req == 1, "R7 upper equals lower", rsp_seg_hit, 0);
    wr(1, 2'd1, LO - 36'd5);
    rq({LO - 36'd3, 12'h000}, 1, 41'h77, 2'b11);
    check(rsp_seg_hit == 0, "R7 upper below lower", rsp_seg_hit, 0);
    // R3: displacement wrap modulo 2^36
    wr(1, 2'd1, HI);
    wr(1, 2'd2, 36'hFFFFFFFFF);
    rq({LO, 12'h123}, 0, '0, 2'b00);
    check(rsp_pa == {LO[28:0] - 29'd1, 12'h123}, "R3 wrap", rsp_pa, {LO[28:0] - 29'd1, 12'h123});

    // Mixed random phase around the bounds, checked by the model every cycle
    wr(1, 2'd2, DISP);
    for (int i = 0; i < 3000; i++) begin
      logic [35:0] vp;
      int pick;
      pick = $urandom_range(0, 9);
      case (pick)
        0: vp = LO - 36'd1;
        1: vp = LO;
        2: vp = HI - 36'd1;
        3: vp = HI;
        default: vp = LO - 36'd8 + 36'($urandom_range(0, 300));
      endcase
      step($urandom_range(0, 15) == 0, $urandom_range(0, 3) != 0,
           2'($urandom_range(0, 3)),
           ($urandom_range(0, 1) == 1) ? LO + 36'($urandom_range(0, 64)) : HI + 36'($urandom_range(0, 64)),
           $urandom_range(0, 3) != 0, {vp, 12'($urandom)},
           $urandom_range(0, 1) == 1, 41'({$urandom, $urandom}), 2'($urandom_range(0, 3)));
    end
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule